// File: doc/BRIEF.md
# Calendar Clock Counter with Staged Commit

This block keeps wall-clock time as seven calendar fields: second, minute, hour, day of month, day of week, month and year. It advances once for every one-cycle pulse on its per-second tick input. The calendar rollover follows real month lengths, and February gains a day in leap years. The year is a 7-bit offset from 1968. Because 1968 is itself a leap year, a leap year is any offset that is a multiple of four.

Software reaches the block over a simple synchronous bus. Writes to the time fields land in holding registers and do not touch the running clock. A write of any value to the commit word starts a fixed-length transfer. At the end of that transfer all seven held values replace the live time in a single cycle. A busy bit in the status word can be polled while the transfer is pending. Reads of the time fields always show the running clock, and seconds keep advancing during a multi-word read. The host can detect a carry by re-reading the seconds field.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the live time reads second 0, minute 0, hour 0, day of month 1, day of week 0, month 1 and year 0. The status word reads 0.
- R2: The time fields are at word addresses 0x0A to 0x10 in this order: second, minute, hour, day of month, day of week, month, year. A write there changes only a holding register. A read there returns the live counter, never the held value.
- R3: A write of any data to word 0x3C starts a commit. Bit 6 of the status word at 0x00 reads 1 for reads sampled on the COMMIT_CYCLES (default 4) edges after the write edge, and 0 afterwards. On the last of those edges all seven held values become the live time together.
- R4: A tick on the same edge as the commit load is discarded. The live time equals the held values exactly.
- R5: Seconds wrap from 59 to 0 with a carry into minutes. Minutes wrap from 59 to 0 with a carry into hours. Hours wrap from 23 to 0 with a carry into the day.
- R6: The day of month goes from the last day of its month to 1 and advances the month. Months 4, 6, 9 and 11 have 30 days, and the other non-February months have 31. February has 29 days when the year field is a multiple of 4 and 28 otherwise.
- R7: The day of week advances once per day carry and wraps from 6 to 0, independently of the day of month.
- R8: Month 12 wraps to 1 and increments the year. Year 127 wraps to 0.
- R9: The stored field widths are: second 6, minute 6, hour 5, day of month 5, day of week 3, month 4, year 7 bits. Write bits above a field's width are discarded, and reads are zero-extended.
- R10: bus_rdata updates on the edge that samples bus_rd. Unmapped words, including the commit word, read 0. Status bits other than bit 6 read 0.
- R11: A commit written while one is pending restarts the full COMMIT_CYCLES interval. Ticks during the interval still advance the live time.
- R12: Without a commit, each tick advances the live time by exactly one second. A read sampled on a tick edge returns the value from before that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |

## Verification
The bench aims at calendar boundaries: leap and common February ends, 30- and 31-day month ends, the year-end carry and the wrap of year 127. A faulty rollover chain shows up there as a wrong day or a missing carry. It times the busy bit edge by edge, including a second commit issued mid-transfer. A design that loaded early, kept busy too long or ignored the restart would return the wrong status on a specific read. A tick placed on the load edge catches a design that adds that second on top of the committed time. Writes without a commit, and over-wide write data, catch a design that shows held values or keeps upper bits. Random times near rollover are then compared against an independent calendar model.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int NUM_FIELDS = 7;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DOM  = 3;
  localparam int F_DOW  = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;

  localparam int SEC_LAST  = 59;
  localparam int MIN_LAST  = 59;
  localparam int HOUR_LAST = 23;
  localparam int DOW_LAST  = 6;
  localparam int MON_LAST  = 12;

  // stored width of each field
  function automatic int field_bits(int idx);
    case (idx)
      F_SEC, F_MIN:   return 6;
      F_HOUR, F_DOM:  return 5;
      F_DOW:          return 3;
      F_MON:          return 4;
      default:        return 7;
    endcase
  endfunction

  // value after reset: 1968-01-01 00:00:00
  function automatic int field_reset(int idx);
    return (idx == F_DOM || idx == F_MON) ? 1 : 0;
  endfunction

  function automatic int month_days(int mon, logic leap);
    case (mon)
      2:             return leap ? 29 : 28;
      4, 6, 9, 11:   return 30;
      default:       return 31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_hold_regs.sv
module rtc_hold_regs
  import rtc_cal_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 6,
  parameter int TIME_BASE = 10
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wr_en,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [DATA_W-1:0]                  wdata,
  output logic [NUM_FIELDS-1:0][DATA_W-1:0]  hold
);
  logic unused_wdata;
  assign unused_wdata = ^wdata;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    localparam int FW = field_bits(g);
    logic [FW-1:0] r;

    always_ff @(posedge clk) begin
      if (rst)
        r <= FW'(field_reset(g));
      else if (wr_en && addr == ADDR_W'(TIME_BASE + g))
        r <= wdata[FW-1:0];
    end

    assign hold[g] = DATA_W'(r);
  end
endmodule

// File: rtl/rtc_commit_seq.sv
module rtc_commit_seq #(
  parameter int COMMIT_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic trigger,
  output logic busy,
  output logic load
);
  localparam int CW = $clog2(COMMIT_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (trigger)
      cnt <= CW'(COMMIT_CYCLES);
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign load = (cnt == CW'(1)) && !trigger;
endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
  import rtc_cal_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               tick,
  input  logic                               load,
  input  logic [NUM_FIELDS-1:0][DATA_W-1:0]  hold,
  output logic [NUM_FIELDS-1:0][DATA_W-1:0]  live
);
  localparam int YEAR_LAST = (1 << field_bits(F_YEAR)) - 1;

  logic [NUM_FIELDS-1:0][DATA_W-1:0] cur, nxt;
  logic              leap;
  logic [DATA_W-1:0] mdays;
  logic c_min, c_hour, c_day, c_mon, c_year;

  always_comb begin
    nxt    = cur;
    leap   = (cur[F_YEAR][1:0] == 2'b00);
    mdays  = DATA_W'(month_days(int'(cur[F_MON]), leap));

    c_min  = cur[F_SEC] >= DATA_W'(SEC_LAST);
    c_hour = c_min  && (cur[F_MIN]  >= DATA_W'(MIN_LAST));
    c_day  = c_hour && (cur[F_HOUR] >= DATA_W'(HOUR_LAST));
    c_mon  = c_day  && (cur[F_DOM]  >= mdays);
    c_year = c_mon  && (cur[F_MON]  >= DATA_W'(MON_LAST));

    nxt[F_SEC] = c_min ? '0 : cur[F_SEC] + DATA_W'(1);
    if (c_min)
      nxt[F_MIN] = (cur[F_MIN] >= DATA_W'(MIN_LAST)) ? '0 : cur[F_MIN] + DATA_W'(1);
    if (c_hour)
      nxt[F_HOUR] = (cur[F_HOUR] >= DATA_W'(HOUR_LAST)) ? '0 : cur[F_HOUR] + DATA_W'(1);
    if (c_day) begin
      nxt[F_DOW] = (cur[F_DOW] >= DATA_W'(DOW_LAST)) ? '0 : cur[F_DOW] + DATA_W'(1);
      nxt[F_DOM] = c_mon ? DATA_W'(1) : cur[F_DOM] + DATA_W'(1);
    end
    if (c_mon)
      nxt[F_MON] = c_year ? DATA_W'(1) : cur[F_MON] + DATA_W'(1);
    if (c_year)
      nxt[F_YEAR] = (cur[F_YEAR] >= DATA_W'(YEAR_LAST)) ? '0 : cur[F_YEAR] + DATA_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_FIELDS; i++)
        cur[i] <= DATA_W'(field_reset(i));
    end else if (load) begin
      cur <= hold;
    end else if (tick) begin
      cur <= nxt;
    end
  end

  assign live = cur;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int ADDR_W        = 6,
  parameter int STATUS_ADDR   = 0,
  parameter int TIME_BASE     = 10,
  parameter int COMMIT_ADDR   = 60,
  parameter int BUSY_BIT      = 6,
  parameter int COMMIT_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  logic [NUM_FIELDS-1:0][DATA_W-1:0] hold_vals;
  logic [NUM_FIELDS-1:0][DATA_W-1:0] live_vals;
  logic              commit_req;
  logic              busy;
  logic              load_now;
  logic [DATA_W-1:0] rd_next;

  assign commit_req = bus_wr && (bus_addr == ADDR_W'(COMMIT_ADDR));

  rtc_hold_regs #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .TIME_BASE(TIME_BASE)
  ) u_hold (
    .clk  (clk),
    .rst  (rst),
    .wr_en(bus_wr),
    .addr (bus_addr),
    .wdata(bus_wdata),
    .hold (hold_vals)
  );

  rtc_commit_seq #(
    .COMMIT_CYCLES(COMMIT_CYCLES)
  ) u_seq (
    .clk    (clk),
    .rst    (rst),
    .trigger(commit_req),
    .busy   (busy),
    .load   (load_now)
  );

  rtc_time_counter #(
    .DATA_W(DATA_W)
  ) u_cnt (
    .clk (clk),
    .rst (rst),
    .tick(tick_1hz),
    .load(load_now),
    .hold(hold_vals),
    .live(live_vals)
  );

  always_comb begin
    rd_next = '0;
    if (bus_addr == ADDR_W'(STATUS_ADDR))
      rd_next[BUSY_BIT] = busy;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (bus_addr == ADDR_W'(TIME_BASE + i))
        rd_next = live_vals[i];
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= rd_next;
  end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
  import rtc_cal_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int ADDR_W        = 6,
  parameter int STATUS_ADDR   = 0,
  parameter int COMMIT_ADDR   = 60,
  parameter int BUSY_BIT      = 6,
  parameter int COMMIT_CYCLES = 4
) (
  input logic                               clk,
  input logic                               rst,
  input logic                               tick_1hz,
  input logic                               bus_wr,
  input logic                               bus_rd,
  input logic [ADDR_W-1:0]                  bus_addr,
  input logic [DATA_W-1:0]                  bus_rdata,
  input logic                               busy,
  input logic                               load_now,
  input logic [NUM_FIELDS-1:0][DATA_W-1:0]  hold,
  input logic [NUM_FIELDS-1:0][DATA_W-1:0]  live
);
  localparam int SW = $clog2(COMMIT_CYCLES + 2);
  localparam logic [SW-1:0] SAT = SW'(COMMIT_CYCLES + 1);

  logic [SW-1:0] since;
  logic          trig;

  assign trig = bus_wr && (bus_addr == ADDR_W'(COMMIT_ADDR));

  always_ff @(posedge clk) begin
    if (rst)
      since <= SAT;
    else if (trig)
      since <= '0;
    else if (since < SAT)
      since <= since + 1'b1;
  end

  a_r3_busy_on_commit: assert property (@(posedge clk) disable iff (rst)
    trig |=> busy);

  a_r3_busy_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> since == SW'(COMMIT_CYCLES));

  a_r3_load_applies: assert property (@(posedge clk) disable iff (rst)
    load_now |=> live == $past(hold));

  a_r4_tick_dropped: assert property (@(posedge clk) disable iff (rst)
    (load_now && tick_1hz) |=> live == $past(hold));

  a_r11_load_only_busy: assert property (@(posedge clk) disable iff (rst)
    load_now |-> busy);

  a_r10_status_read: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(STATUS_ADDR)) |=> bus_rdata[BUSY_BIT] == $past(busy));

  a_r12_sec_step: assert property (@(posedge clk) disable iff (rst)
    (tick_1hz && !load_now && live[F_SEC] < DATA_W'(SEC_LAST))
      |=> live[F_SEC] == $past(live[F_SEC]) + DATA_W'(1));

  a_r8_year_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick_1hz && !load_now && live[F_SEC] == DATA_W'(59) && live[F_MIN] == DATA_W'(59)
     && live[F_HOUR] == DATA_W'(23) && live[F_DOM] == DATA_W'(31)
     && live[F_MON] == DATA_W'(12) && live[F_YEAR] == DATA_W'(127))
      |=> (live[F_YEAR] == '0 && live[F_MON] == DATA_W'(1) && live[F_DOM] == DATA_W'(1)));
endmodule

bind rtc_calendar rtc_calendar_chk #(
  .DATA_W       (DATA_W),
  .ADDR_W       (ADDR_W),
  .STATUS_ADDR  (STATUS_ADDR),
  .COMMIT_ADDR  (COMMIT_ADDR),
  .BUSY_BIT     (BUSY_BIT),
  .COMMIT_CYCLES(COMMIT_CYCLES)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick_1hz (tick_1hz),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata),
  .busy     (busy),
  .load_now (load_now),
  .hold     (hold_vals),
  .live     (live_vals)
);

// File: tb/test_rtc_calendar.sv
module test_rtc_calendar;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 6;
  localparam int A_STATUS   = 0;
  localparam int A_TIME     = 10;
  localparam int A_COMMIT   = 60;
  localparam int COMMIT_CYC = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tick_1hz = 1'b0;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  int m[7];

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_calendar i_rtc_calendar (
    .clk      (clk),
    .rst      (rst),
    .tick_1hz (tick_1hz),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  function automatic int days_of(int mon, int year);
    if (mon == 2) return (year % 4 == 0) ? 29 : 28;
    return 30 + ((mon + ((mon >= 8) ? 1 : 0)) % 2);
  endfunction

  task automatic model_tick();
    m[0]++;
    if (m[0] == 60) begin
      m[0] = 0; m[1]++;
      if (m[1] == 60) begin
        m[1] = 0; m[2]++;
        if (m[2] == 24) begin
          m[2] = 0;
          m[4] = (m[4] + 1) % 7;
          m[3]++;
          if (m[3] > days_of(m[5], m[6])) begin
            m[3] = 1; m[5]++;
            if (m[5] > 12) begin
              m[5] = 1;
              m[6] = (m[6] + 1) % 128;
            end
          end
        end
      end
    end
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic bus_write(int a, int d);
    bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = DATA_W'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(int a, output int v);
    bus_rd = 1'b1; bus_addr = ADDR_W'(a);
    @(negedge clk);
    v = int'(bus_rdata);
    bus_rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_tick();
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
    model_tick();
  endtask

  task automatic set_time(int s, int mi, int h, int d, int w, int mo, int y);
    bus_write(A_TIME + 0, s);
    bus_write(A_TIME + 1, mi);
    bus_write(A_TIME + 2, h);
    bus_write(A_TIME + 3, d);
    bus_write(A_TIME + 4, w);
    bus_write(A_TIME + 5, mo);
    bus_write(A_TIME + 6, y);
    bus_write(A_COMMIT, 0);
    idle(COMMIT_CYC);
    m[0] = s; m[1] = mi; m[2] = h; m[3] = d; m[4] = w; m[5] = mo; m[6] = y;
  endtask

  task automatic check_all(string req);
    int v;
    for (int i = 0; i < 7; i++) begin
      bus_read(A_TIME + i, v);
      check(req, v, m[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v;
    int s0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    m[0] = 0; m[1] = 0; m[2] = 0; m[3] = 1; m[4] = 0; m[5] = 1; m[6] = 0;
    bus_read(A_STATUS, v); check("R1 status", v, 0);
    check_all("R1 reset time");

    // R10 unmapped and commit words read 0
    bus_read(32, v);       check("R10 unmapped", v, 0);
    bus_read(A_COMMIT, v); check("R10 commit word", v, 0);

    // R12 plain ticks
    for (int i = 0; i < 5; i++) do_tick();
    check_all("R12 ticks");

    // R2 held write does not show up, ticks continue
    bus_write(A_TIME + 0, 33);
    bus_read(A_TIME + 0, v); check("R2 live not held", v, m[0]);
    do_tick();
    bus_read(A_TIME + 0, v); check("R2 after tick", v, m[0]);

    // R3 busy window and load timing
    set_time(10, 20, 5, 15, 3, 6, 50);
    bus_write(A_TIME + 1, 44);
    bus_write(A_COMMIT, 8'hA5);
    for (int i = 0; i < COMMIT_CYC; i++) begin
      bus_read(A_STATUS, v); check("R3 busy high", v, 8'h40);
    end
    bus_read(A_STATUS, v); check("R3 busy low", v, 0);
    m[1] = 44;
    check_all("R3 committed");

    bus_write(A_TIME + 2, 7);
    bus_write(A_COMMIT, 0);
    for (int i = 0; i < COMMIT_CYC; i++) begin
      bus_read(A_TIME + 2, v); check("R3 old until load", v, 5);
    end
    bus_read(A_TIME + 2, v); check("R3 new after load", v, 7);
    m[2] = 7;

    // R11 restart while busy
    bus_write(A_COMMIT, 0);
    bus_read(A_STATUS, v); check("R11 busy 1", v, 8'h40);
    bus_read(A_STATUS, v); check("R11 busy 2", v, 8'h40);
    bus_write(A_COMMIT, 0);
    for (int i = 0; i < COMMIT_CYC; i++) begin
      bus_read(A_STATUS, v); check("R11 restarted busy", v, 8'h40);
    end
    bus_read(A_STATUS, v); check("R11 busy cleared", v, 0);

    // R11 ticks during busy still count (before the load overwrites)
    bus_write(A_COMMIT, 0);
    do_tick();
    bus_read(A_TIME + 0, v); check("R11 tick while busy", v, m[0]);
    idle(2);
    m[0] = 10; m[1] = 44; m[2] = 7; m[3] = 15; m[4] = 3; m[5] = 6; m[6] = 50;
    check_all("R11 load after ticks");

    // R12 read on tick edge returns pre-tick value
    s0 = m[0];
    tick_1hz = 1'b1; bus_rd = 1'b1; bus_addr = ADDR_W'(A_TIME);
    @(negedge clk);
    v = int'(bus_rdata);
    tick_1hz = 1'b0; bus_rd = 1'b0;
    model_tick();
    check("R12 read on tick edge", v, s0);
    bus_read(A_TIME, v); check("R12 next read", v, s0 + 1);

    // R4 tick on load edge is dropped
    bus_write(A_TIME + 0, 30);
    bus_write(A_COMMIT, 0);
    idle(COMMIT_CYC - 1);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
    m[0] = 30;
    bus_read(A_TIME, v); check("R4 tick dropped", v, 30);

    // R9 upper bits discarded
    bus_write(A_TIME + 0, 8'hC5);
    bus_write(A_TIME + 1, 8'h7B);
    bus_write(A_TIME + 2, 8'hF7);
    bus_write(A_TIME + 3, 8'hFF);
    bus_write(A_TIME + 4, 8'h0D);
    bus_write(A_TIME + 5, 8'h31);
    bus_write(A_TIME + 6, 8'hE5);
    bus_write(A_COMMIT, 0);
    idle(COMMIT_CYC);
    m[0] = 5; m[1] = 59; m[2] = 23; m[3] = 31; m[4] = 5; m[5] = 1; m[6] = 101;
    check_all("R9 field masks");

    // R5 carry chain
    set_time(59, 59, 22, 10, 2, 3, 7);
    do_tick(); check_all("R5 hour carry");
    set_time(59, 14, 3, 10, 2, 3, 7);
    do_tick(); check_all("R5 minute carry");

    // R6 month lengths and leap years
    set_time(59, 59, 23, 28, 1, 2, 0);  do_tick(); check_all("R6 leap feb 28");
    check("R6 leap day", m[3], 29);
    do_tick();
    set_time(59, 59, 23, 29, 1, 2, 4);  do_tick(); check_all("R6 leap feb 29");
    set_time(59, 59, 23, 28, 1, 2, 1);  do_tick(); check_all("R6 common feb");
    set_time(59, 59, 23, 30, 1, 4, 9);  do_tick(); check_all("R6 30-day month");
    set_time(59, 59, 23, 30, 1, 8, 9);  do_tick(); check_all("R6 31-day not end");
    set_time(59, 59, 23, 31, 1, 1, 9);  do_tick(); check_all("R6 jan end");

    // R7 day of week wrap
    set_time(59, 59, 23, 5, 6, 5, 20);  do_tick(); check_all("R7 dow wrap");

    // R8 year end and year wrap
    set_time(59, 59, 23, 31, 3, 12, 55);  do_tick(); check_all("R8 year end");
    set_time(59, 59, 23, 31, 6, 12, 127); do_tick(); check_all("R8 year wrap");

    // random times near rollover
    for (int it = 0; it < 30; it++) begin
      int s, mi, h, mo, y, d, w, n;
      s  = 50 + $urandom % 10;
      mi = ($urandom % 2) ? 59 : $urandom % 60;
      h  = ($urandom % 2) ? 23 : $urandom % 24;
      mo = 1 + $urandom % 12;
      y  = $urandom % 128;
      d  = days_of(mo, y) - ($urandom % 2);
      w  = $urandom % 7;
      n  = $urandom % 12;
      set_time(s, mi, h, d, w, mo, y);
      for (int k = 0; k < n; k++) do_tick();
      check_all("R12 random R6 R8");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule